// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block holds the configuration and the pointer state for four circular descriptor rings that sit between software and a packet engine. The rings are, in index order, receive-free (ring 0), receive-busy (ring 1), transmit-busy (ring 2) and transmit-return (ring 3). Each ring has a base address, a depth and two pointers. Software owns one pointer of each ring and the packet engine owns the other. Software fills the receive-free ring and the engine takes from it. The engine posts received frames on the receive-busy ring and software takes them back. Software submits frames on the transmit-busy ring and the engine takes them. The engine posts completions on the transmit-return ring.

Software reaches the block through a register bus: a write strobe, a 6-bit word address, 32-bit write data and combinational read data. The address splits into a group field `reg_addr[5:3]` (rings 0 to 3, group 4 for global registers) and a field selector `reg_addr[2:0]`. The selector codes are 0 for base, 1 for depth, 2 for write pointer, 3 for read pointer and 4 for the ring's configuration lock register. The hardware side has one request/ready pair for each ring. Each pair also presents the descriptor address at the engine-owned pointer, and the block reports empty and full flags for all four rings. The block produces addresses only. It moves no data.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset every base, depth, pointer, lock and global gate register reads zero, `ring_empty` and `ring_full` are 4'hF, and every ready output is low.
- R2: A write to a ring's depth field (selector 1) takes effect only while bit 1 of that ring's lock register (selector 4) is set. The stored descriptor count is `wdata[9:3]`, and the field reads back as the count shifted left by 3.
- R3: A write to a ring's base field (selector 0) takes effect only while bit 2 of that ring's lock register is set. The field reads back all 32 bits. The lock register reads back bits 2:1 only.
- R4: Pointers read back as byte offsets, which are the descriptor index shifted left by 5, with bits 4:0 always zero. Software writes store the index from `wdata[10:5]`. Only the software-owned pointer accepts software writes: write pointer on rings 0 and 2, read pointer on rings 1 and 3. A write to the engine-owned pointer is ignored.
- R5: A ring is empty when its pointers are equal. It is full when the write pointer's successor equals the read pointer, so one slot always stays unused. A ring with depth zero reports both empty and full.
- R6: A pointer advanced by the engine goes from index depth-1 back to index 0.
- R7: Take on ring 0 or ring 2 is ready only when that ring is not empty and its global gate bit is set: bit 2 for ring 0 and bit 0 for ring 2. A take while ready advances the read pointer by one descriptor.
- R8: Post on ring 1 or ring 3 is ready only when that ring is not full and its global gate bit is set: bit 3 for ring 1 and bit 1 for ring 3. A post while ready advances the write pointer by one descriptor. A request while not ready stalls and leaves the pointer unchanged.
- R9: Each ring's address output equals its base plus 32 times the index of the engine-owned pointer. That pointer is the read pointer on rings 0 and 2 and the write pointer on rings 1 and 3.
- R10: The global gate register is at word address 0x20 and stores `wdata[3:0]`. It reads back with bits 31:4 zero.
- R11: Selectors 5 to 7, groups 5 to 7 and the unused selectors of group 4 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address (group, selector) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rxf_req | input | 1 | Engine takes the next free receive descriptor |
| rxf_ready | output | 1 | Receive-free take may proceed |
| rxf_addr | output | 32 | Address of the next free receive descriptor |
| rxb_req | input | 1 | Engine posts a received frame |
| rxb_ready | output | 1 | Receive-busy post may proceed |
| rxb_addr | output | 32 | Address of the receive-busy slot to fill |
| txb_req | input | 1 | Engine takes a pending transmit descriptor |
| txb_ready | output | 1 | Transmit-busy take may proceed |
| txb_addr | output | 32 | Address of the pending transmit descriptor |
| txr_req | input | 1 | Engine posts a transmit completion |
| txr_ready | output | 1 | Transmit-return post may proceed |
| txr_addr | output | 32 | Address of the transmit-return slot to fill |
| ring_empty | output | 4 | Per-ring empty flag, bit n for ring n |
| ring_full | output | 4 | Per-ring full flag, bit n for ring n |

## Verification
The checks assume that software writes only pointer indices below the ring's programmed depth, and depths no greater than 64. They also assume that the register bus and the engine are the only sources of pointer motion. With those inputs, an empty transmit-busy ring or a full receive-busy ring can change state only through a register write. The random phase keeps within this: it programs depths of 1 to 64 and draws each software pointer index modulo the current depth. It also changes the gate register and the pointers only through ordinary bus writes, mixed with random engine requests on all four rings.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    localparam int NUM_RINGS   = 4;
    localparam int DESC_SHIFT  = 5;   // 32-byte descriptors
    localparam int DEPTH_SHIFT = 3;   // depth register holds count << 3
    localparam int REG_AW      = 6;

    typedef enum logic [2:0] {
        FLD_BASE  = 3'd0,
        FLD_DEPTH = 3'd1,
        FLD_WPTR  = 3'd2,
        FLD_RPTR  = 3'd3,
        FLD_LOCK  = 3'd4
    } fld_e;

    localparam logic [2:0] GLOBAL_GRP = 3'd4;

    // rings 0 (receive free) and 2 (transmit busy) are filled by software
    function automatic bit sw_owns_wr(input int ring);
        return (ring == 0) || (ring == 2);
    endfunction

    // global gate bit that enables the engine on each ring
    function automatic int gate_bit(input int ring);
        case (ring)
            0:       return 2;
            1:       return 3;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/desc_ring_unit.sv
module desc_ring_unit
    import desc_ring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 6,
    parameter bit SW_WR = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  fld_e          cfg_fld,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          hw_adv,
    output logic [DW-1:0] cfg_rdata,
    output logic          hw_ok,
    output logic [DW-1:0] hw_addr,
    output logic          is_empty,
    output logic          is_full
);
    localparam int CNT_W = IDX_W + 1;

    logic [DW-1:0]    base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] wr_q, rd_q, hw_ptr;
    logic [1:0]       lock_q;   // {base unlock, depth unlock}

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p,
                                              input logic [CNT_W-1:0] n);
        logic [CNT_W-1:0] inc;
        inc = {1'b0, p} + CNT_W'(1);
        return (inc == n) ? '0 : inc[IDX_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            lock_q <= '0;
        end else begin
            if (cfg_wr) begin
                case (cfg_fld)
                    FLD_LOCK:  lock_q <= cfg_wdata[2:1];
                    FLD_DEPTH: if (lock_q[0]) cnt_q <= cfg_wdata[DEPTH_SHIFT +: CNT_W];
                    FLD_BASE:  if (lock_q[1]) base_q <= cfg_wdata;
                    FLD_WPTR:  if (SW_WR)  wr_q <= cfg_wdata[DESC_SHIFT +: IDX_W];
                    FLD_RPTR:  if (!SW_WR) rd_q <= cfg_wdata[DESC_SHIFT +: IDX_W];
                    default: ;
                endcase
            end
            if (hw_adv) begin
                if (SW_WR) rd_q <= step(rd_q, cnt_q);
                else       wr_q <= step(wr_q, cnt_q);
            end
        end
    end

    always_comb begin
        is_empty = (cnt_q == '0) || (wr_q == rd_q);
        is_full  = (cnt_q == '0) || (step(wr_q, cnt_q) == rd_q);
        hw_ptr   = SW_WR ? rd_q : wr_q;
        hw_ok    = SW_WR ? !is_empty : !is_full;
        hw_addr  = base_q + (DW'(hw_ptr) << DESC_SHIFT);
    end

    always_comb begin
        case (cfg_fld)
            FLD_BASE:  cfg_rdata = base_q;
            FLD_DEPTH: cfg_rdata = DW'(cnt_q) << DEPTH_SHIFT;
            FLD_WPTR:  cfg_rdata = DW'(wr_q) << DESC_SHIFT;
            FLD_RPTR:  cfg_rdata = DW'(rd_q) << DESC_SHIFT;
            FLD_LOCK:  cfg_rdata = DW'({lock_q, 1'b0});
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/desc_ring_regif.sv
module desc_ring_regif
    import desc_ring_pkg::*;
#(
    parameter int DW = 32,
    parameter int NR = NUM_RINGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [DW-1:0]     ring_rdata [NR],
    output logic [NR-1:0]     ring_wr,
    output fld_e              fld,
    output logic [3:0]        gate_q,
    output logic [DW-1:0]     reg_rdata
);
    localparam int IW = (NR > 1) ? $clog2(NR) : 1;

    logic [2:0] grp;
    logic       fld_ok, is_gate;

    always_comb begin
        grp     = reg_addr[5:3];
        fld     = fld_e'(reg_addr[2:0]);
        fld_ok  = (reg_addr[2:0] <= 3'd4);
        is_gate = (reg_addr == {GLOBAL_GRP, 3'b000});
        for (int i = 0; i < NR; i++)
            ring_wr[i] = reg_wr && fld_ok && (grp == 3'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gate_q <= '0;
        else if (reg_wr && is_gate) gate_q <= reg_wdata[3:0];
    end

    always_comb begin
        if (fld_ok && (32'(grp) < NR)) reg_rdata = ring_rdata[grp[IW-1:0]];
        else if (is_gate)              reg_rdata = DW'(gate_q);
        else                           reg_rdata = '0;
    end

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
    import desc_ring_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rxf_req,
    output logic        rxf_ready,
    output logic [31:0] rxf_addr,
    input  logic        rxb_req,
    output logic        rxb_ready,
    output logic [31:0] rxb_addr,
    input  logic        txb_req,
    output logic        txb_ready,
    output logic [31:0] txb_addr,
    input  logic        txr_req,
    output logic        txr_ready,
    output logic [31:0] txr_addr,
    output logic [3:0]  ring_empty,
    output logic [3:0]  ring_full
);
    localparam int DW = 32;

    logic [NUM_RINGS-1:0] ring_wr, hw_req, hw_ok, hw_ready;
    logic [DW-1:0]        ring_rdata [NUM_RINGS];
    logic [DW-1:0]        hw_addr    [NUM_RINGS];
    logic [3:0]           gate_q;
    fld_e                 fld;

    assign hw_req = {txr_req, txb_req, rxb_req, rxf_req};

    desc_ring_regif #(.DW(DW), .NR(NUM_RINGS)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ring_rdata (ring_rdata),
        .ring_wr    (ring_wr),
        .fld        (fld),
        .gate_q     (gate_q),
        .reg_rdata  (reg_rdata)
    );

    for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
        assign hw_ready[i] = hw_ok[i] && gate_q[gate_bit(i)];

        desc_ring_unit #(.DW(DW), .IDX_W(IDX_W), .SW_WR(sw_owns_wr(i))) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (ring_wr[i]),
            .cfg_fld   (fld),
            .cfg_wdata (reg_wdata),
            .hw_adv    (hw_req[i] && hw_ready[i]),
            .cfg_rdata (ring_rdata[i]),
            .hw_ok     (hw_ok[i]),
            .hw_addr   (hw_addr[i]),
            .is_empty  (ring_empty[i]),
            .is_full   (ring_full[i])
        );
    end

    assign rxf_ready = hw_ready[0];
    assign rxb_ready = hw_ready[1];
    assign txb_ready = hw_ready[2];
    assign txr_ready = hw_ready[3];
    assign rxf_addr  = hw_addr[0];
    assign rxb_addr  = hw_addr[1];
    assign txb_addr  = hw_addr[2];
    assign txr_addr  = hw_addr[3];

endmodule

// File: rtl/desc_ring_ctrl_chk.sv
module desc_ring_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [5:0]  reg_addr,
    input logic        rxb_req,
    input logic        rxb_ready,
    input logic [31:0] rxb_addr,
    input logic [3:0]  ring_empty,
    input logic [3:0]  ring_full
);
    // R8: a stalled post leaves the receive-busy slot where it was
    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rxb_req && !rxb_ready && !reg_wr |=> $stable(rxb_addr));

    // R6: an accepted post moves the slot (to the next index or back to 0)
    assert_post_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rxb_req && rxb_ready && !reg_wr |=> rxb_addr != $past(rxb_addr));

    // R7: the engine alone cannot make an empty transmit-busy ring non-empty
    assert_txb_empty_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty[2] && !reg_wr |=> ring_empty[2]);

    // R5: a full receive-busy ring stays full until software frees a slot
    assert_rxb_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full[1] && !reg_wr |=> ring_full[1]);

    // R4: software write to the engine-owned pointer of ring 1 is ignored
    assert_hw_ptr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 6'h0A) && !rxb_req |=> $stable(rxb_addr));

endmodule

bind desc_ring_ctrl desc_ring_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .rxb_req    (rxb_req),
    .rxb_ready  (rxb_ready),
    .rxb_addr   (rxb_addr),
    .ring_empty (ring_empty),
    .ring_full  (ring_full)
);

// File: tb/desc_ring_ctrl_test.sv
module desc_ring_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [3:0]  req;
    logic        rxf_ready, rxb_ready, txb_ready, txr_ready;
    logic [31:0] rxf_addr, rxb_addr, txb_addr, txr_addr;
    logic [3:0]  ring_empty, ring_full;
    logic [3:0]  rdy;
    logic [31:0] haddr [4];

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int          m_cnt [4];
    logic [31:0] m_base [4];
    int          m_wr [4];
    int          m_rd [4];
    logic [3:0]  m_gate;

    always #10 clk = ~clk;

    desc_ring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxf_req(req[0]), .rxf_ready(rxf_ready), .rxf_addr(rxf_addr),
        .rxb_req(req[1]), .rxb_ready(rxb_ready), .rxb_addr(rxb_addr),
        .txb_req(req[2]), .txb_ready(txb_ready), .txb_addr(txb_addr),
        .txr_req(req[3]), .txr_ready(txr_ready), .txr_addr(txr_addr),
        .ring_empty(ring_empty), .ring_full(ring_full)
    );

    assign rdy = {txr_ready, txb_ready, rxb_ready, rxf_ready};
    assign haddr[0] = rxf_addr;
    assign haddr[1] = rxb_addr;
    assign haddr[2] = txb_addr;
    assign haddr[3] = txr_addr;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ra(input int grp, input int fld);
        return {3'(grp), 3'(fld)};
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic hw(input int k, input bit exp, input string tag);
        @(negedge clk);
        req[k] = 1'b1;
        #1 chk(tag, 32'(rdy[k]), 32'(exp));
        @(negedge clk);
        req[k] = 1'b0;
    endtask

    task automatic cfg(input int k, input int cnt, input logic [31:0] base);
        wr(ra(k, 4), 32'h6);
        wr(ra(k, 1), 32'(cnt) << 3);
        wr(ra(k, 0), base);
        wr(ra(k, 4), 32'h0);
    endtask

    task automatic do_reset();
        req = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic bit m_sw(input int k);  return (k == 0) || (k == 2); endfunction
    function automatic int m_gbit(input int k);
        case (k) 0: return 2; 1: return 3; 2: return 0; default: return 1; endcase
    endfunction
    function automatic int m_nx(input int k, input int p);
        return (p + 1 == m_cnt[k]) ? 0 : p + 1;
    endfunction
    function automatic bit m_empty(input int k);
        return (m_cnt[k] == 0) || (m_wr[k] == m_rd[k]);
    endfunction
    function automatic bit m_full(input int k);
        return (m_cnt[k] == 0) || (m_nx(k, m_wr[k]) == m_rd[k]);
    endfunction
    function automatic bit m_ready(input int k);
        return (m_sw(k) ? !m_empty(k) : !m_full(k)) && m_gate[m_gbit(k)];
    endfunction
    function automatic logic [31:0] m_addr(input int k);
        return m_base[k] + (32'(m_sw(k) ? m_rd[k] : m_wr[k]) << 5);
    endfunction
    function automatic logic [31:0] m_read(input logic [5:0] a);
        int g = int'(a[5:3]);
        int f = int'(a[2:0]);
        if (g < 4) begin
            case (f)
                0: return m_base[g];
                1: return 32'(m_cnt[g]) << 3;
                2: return 32'(m_wr[g]) << 5;
                3: return 32'(m_rd[g]) << 5;
                default: return 32'h0;   // lock is left cleared
            endcase
        end
        if (a == 6'h20) return {28'h0, m_gate};
        return 32'h0;
    endfunction

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd5150);
        do_reset();

        // R1 reset state
        rdchk(ra(0, 0), 32'h0, "R1 base");
        rdchk(ra(2, 1), 32'h0, "R1 depth");
        rdchk(ra(3, 3), 32'h0, "R1 rptr");
        rdchk(6'h20, 32'h0, "R1 gate");
        chk("R1 empty", 32'(ring_empty), 32'hF);
        chk("R1 full", 32'(ring_full), 32'hF);
        chk("R1 ready", 32'(rdy), 32'h0);

        // R2 depth lock
        wr(ra(1, 1), 32'd4 << 3);
        rdchk(ra(1, 1), 32'h0, "R2 depth locked");
        wr(ra(1, 4), 32'h2);
        wr(ra(1, 1), 32'd4 << 3);
        rdchk(ra(1, 1), 32'd32, "R2 depth unlocked");
        wr(ra(1, 0), 32'h1000);
        rdchk(ra(1, 0), 32'h0, "R3 base needs bit 2");
        wr(ra(1, 4), 32'hFFFF_FFFF);
        rdchk(ra(1, 4), 32'h6, "R3 lock readback");
        wr(ra(1, 0), 32'h1000);
        rdchk(ra(1, 0), 32'h1000, "R3 base unlocked");
        wr(ra(1, 4), 32'h0);
        wr(ra(1, 1), 32'd8 << 3);
        rdchk(ra(1, 1), 32'd32, "R2 depth relocked");

        // R10 global gate
        wr(6'h20, 32'hFFFF_FFF0);
        rdchk(6'h20, 32'h0, "R10 upper bits");
        wr(6'h20, 32'hF);
        rdchk(6'h20, 32'hF, "R10 gate");

        // R11 unmapped
        wr(6'h3F, 32'hFFFF_FFFF);
        wr(6'h25, 32'hFFFF_FFFF);
        rdchk(6'h3F, 32'h0, "R11 group 7");
        rdchk(6'h07, 32'h0, "R11 selector 7");
        rdchk(6'h20, 32'hF, "R11 gate untouched");

        // R4 pointer ownership on ring 1
        wr(ra(1, 2), 32'd2 << 5);
        rdchk(ra(1, 2), 32'h0, "R4 engine pointer ignored");
        chk("R4 address unchanged", rxb_addr, 32'h1000);
        wr(ra(1, 3), (32'd3 << 5) | 32'h7);
        rdchk(ra(1, 3), 32'd96, "R4 software pointer");
        wr(ra(1, 3), 32'h0);

        // R8 / R6 / R5 on ring 3, depth 3
        cfg(3, 3, 32'h2000);
        chk("R9 txr addr", txr_addr, 32'h2000);
        hw(3, 1'b1, "R8 post ready");
        chk("R9 txr addr step", txr_addr, 32'h2020);
        hw(3, 1'b1, "R8 post ready 2");
        chk("R5 full one slot spare", 32'(ring_full[3]), 32'h1);
        hw(3, 1'b0, "R8 stall when full");
        rdchk(ra(3, 2), 32'd64, "R8 stalled pointer");
        wr(ra(3, 3), 32'd32);
        chk("R5 not full", 32'(ring_full[3]), 32'h0);
        hw(3, 1'b1, "R8 post after free");
        rdchk(ra(3, 2), 32'h0, "R6 wrap pointer");
        chk("R6 wrap address", txr_addr, 32'h2000);

        // R7 on ring 2, depth 2
        cfg(2, 2, 32'h3000);
        chk("R5 empty", 32'(ring_empty[2]), 32'h1);
        chk("R7 not ready empty", 32'(txb_ready), 32'h0);
        wr(ra(2, 2), 32'd32);
        chk("R9 txb addr", txb_addr, 32'h3000);
        hw(2, 1'b1, "R7 take ready");
        chk("R9 txb addr step", txb_addr, 32'h3020);
        chk("R7 empty after take", 32'(txb_ready), 32'h0);
        wr(6'h20, 32'hE);
        wr(ra(2, 2), 32'd0);
        chk("R7 gate bit 0 blocks", 32'(txb_ready), 32'h0);
        chk("R5 depth zero", {28'h0, ring_empty[0], ring_full[0], rxf_ready, 1'b0}, 32'hC);

        // random phase against the model
        do_reset();
        for (int k = 0; k < 4; k++) begin
            m_cnt[k]  = (k == 0) ? 64 : 1 + int'($urandom % 7);
            m_base[k] = $urandom;
            m_wr[k]   = 0;
            m_rd[k]   = 0;
            cfg(k, m_cnt[k], m_base[k]);
        end
        m_gate = 4'h0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int act, k;
            logic [31:0] d;
            @(negedge clk);
            act = int'($urandom % 8);
            k = int'($urandom % 4);
            d = $urandom;
            reg_wr = 1'b0;
            if (act == 0) begin
                reg_wr = 1'b1; reg_addr = 6'h20; reg_wdata = d;
            end else if (act <= 2) begin
                reg_wr = 1'b1;
                reg_addr = ra(k, m_sw(k) ? 2 : 3);
                reg_wdata = (32'(int'(d % 32'(m_cnt[k]))) << 5) | 32'(d[31:27]);
            end else begin
                reg_addr = 6'($urandom);
            end
            req = 4'($urandom);
            #1;
            for (int j = 0; j < 4; j++) begin
                chk($sformatf("R7/R8 ready ring%0d", j), 32'(rdy[j]), 32'(m_ready(j)));
                chk($sformatf("R9 addr ring%0d", j), haddr[j], m_addr(j));
                chk($sformatf("R5 empty ring%0d", j), 32'(ring_empty[j]), 32'(m_empty(j)));
                chk($sformatf("R5 full ring%0d", j), 32'(ring_full[j]), 32'(m_full(j)));
            end
            if (!reg_wr) chk("R11 random read", reg_rdata, m_read(reg_addr));
            // model next state (R6 wrap via m_nx)
            for (int j = 0; j < 4; j++) begin
                if (req[j] && m_ready(j)) begin
                    if (m_sw(j)) m_rd[j] = m_nx(j, m_rd[j]);
                    else         m_wr[j] = m_nx(j, m_wr[j]);
                end
            end
            if (act == 0) m_gate = d[3:0];
            else if (act <= 2) begin
                if (m_sw(k)) m_wr[k] = int'(reg_wdata[10:5]);
                else         m_rd[k] = int'(reg_wdata[10:5]);
            end
        end
        @(negedge clk);
        req = '0; reg_wr = 1'b0;
        summary();
        $finish;
    end

endmodule